// File: doc/BRIEF.md
# Half-Duplex Transmit Retry Sequencer

This block sits between a frame source and a half-duplex transmitter and runs one transmit attempt at a time. Bytes arrive as a stream with start and end marks. In the cycle a byte is accepted it is passed straight to the transmit side. It is also copied into a local replay store that holds the opening bytes of the frame. When the medium reports a collision, the attempt is cut off and the sequencer waits a random backoff. It then sends the frame again, taking the stored opening bytes from the replay store and pulling from the source only where the stored bytes run out. A retry budget bounds the number of attempts. A collision that arrives after the stored window has gone out cannot be replayed, so it is reported instead.

A halt request stops the transmitter only at a frame boundary. If it arrives while the block is idle, it takes effect at once. If it arrives during a frame, it waits until that frame ends, either by sending its last byte or by a collision. A one-cycle completion pulse marks the moment the transmitter has stopped. When the request is withdrawn, the transmitter carries on with the next frame. If a collision cut the frame short, that next frame is the interrupted one, sent again from its first byte.

The controller has five states. In IDLE it waits for a start mark. In SEND an attempt is running. In BACKOFF the random delay counts down. In DRAIN the rest of an abandoned frame is discarded. In STOPPED the transmitter is halted. The transitions are:
- IDLE→STOPPED on a halt request.
- IDLE→SEND on a start-marked byte.
- SEND→IDLE on the last byte.
- SEND→BACKOFF on a retryable collision.
- SEND→STOPPED on a retryable collision while a halt is requested.
- SEND→DRAIN on a late collision or an exhausted budget.
- BACKOFF→SEND when the delay expires.
- DRAIN→IDLE on the end-marked input byte.
- STOPPED→IDLE or STOPPED→SEND when the halt is withdrawn; SEND is taken when a frame is held.

Top module: `hdx_retry_seq`

## Requirements
- R1: After reset the block is in IDLE. tx_valid, halt_done, err_late and err_retry are low, and in_ready is high while no start-marked byte is offered.
- R2: On the first attempt, each byte the source offers is accepted (in_ready high) and appears on tx_data with tx_valid in the same cycle. tx_sof is high on the frame's first byte and tx_eof on the byte that carries in_eof.
- R3: In IDLE, a byte offered without in_sof is accepted and dropped, and nothing appears on the transmit side.
- R4: After a retryable collision, the next attempt resends the frame from its first byte. Bytes that were already accepted come from the replay store with in_ready low. Later bytes are pulled from the source. The transmit byte sequence equals the frame.
- R5: When collision number n of a frame (n counted from 1) is raised in cycle c, the first byte of the next attempt appears in cycle c + 2 + s·SLOT_CYCLES, where s is a whole number of slots.
- R6: A collision in SEND suppresses the byte of that cycle. The byte is neither sent nor accepted, and this includes a byte that carries in_eof.
- R7: A collision that arrives when RETRY_LIMIT retries of the frame have already been made raises err_retry in that cycle. The frame is then abandoned: its remaining bytes are accepted and dropped up to in_eof, and nothing is transmitted.
- R8: A collision that arrives after BUF_DEPTH bytes of the current attempt have gone out is late. It raises err_late in that cycle and is not retried, and the frame is drained as in R7. A collision after BUF_DEPTH−1 bytes is still retried.
- R9: The retry count restarts at zero with every new frame.
- R10: A halt request seen in IDLE raises halt_done in that cycle. While the halt is held, no byte is accepted or sent. Withdrawing it lets the next frame start.
- R11: A halt request raised during a frame lets that frame finish. halt_done pulses once, in the cycle after the byte carrying tx_eof.
- R12: A retryable collision while a halt is requested raises halt_done in the collision cycle and starts no backoff. The first byte of the resent frame appears in the cycle after the one in which the halt is withdrawn.
- R13: The slot count s of R5 is at most 2^min(n, BACKOFF_CAP) − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_sof | input | 1 | Source byte is the first of a frame |
| in_eof | input | 1 | Source byte is the last of a frame |
| in_ready | output | 1 | Source byte accepted this cycle |
| col_in | input | 1 | Collision seen on the medium |
| halt_req | input | 1 | Graceful stop request (level) |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_sof | output | 1 | Transmit byte is the first of an attempt |
| tx_eof | output | 1 | Transmit byte ends the frame |
| halt_done | output | 1 | One-cycle pulse: transmitter has stopped |
| err_late | output | 1 | One-cycle pulse: late collision, frame dropped |
| err_retry | output | 1 | One-cycle pulse: retry budget spent, frame dropped |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes each on purpose. First, a collision can coincide with the frame's last byte. The bench raises the collision just as the end-marked byte is about to go out, then requires that byte to be neither sent nor accepted and the frame to be resent whole. Second, a collision can coincide with a pending halt request. The bench holds the halt from earlier in the frame and collides later. It then expects halt_done in the collision cycle itself, no backoff, silence while the halt is held, and the replay starting exactly one cycle after the halt is withdrawn.

// File: rtl/hdx_retry_pkg.sv
package hdx_retry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_BACKOFF,
        ST_DRAIN,
        ST_STOPPED
    } hdx_state_e;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/hdx_replay_mem.sv
module hdx_replay_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/hdx_backoff_timer.sv
module hdx_backoff_timer
    import hdx_retry_pkg::*;
#(
    parameter int SLOT_CYCLES          = 512,
    parameter int CAP_EXP              = 10,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
    localparam int EW                  = $clog2(CAP_EXP + 1),
    localparam int SW                  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [EW-1:0] exp_in,
    output logic          done
);

    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYCLES - 1);

    logic [LFSR_W-1:0]  lfsr_q;
    logic [LFSR_W-1:0]  lfsr_d;
    logic [CAP_EXP-1:0] mask;
    logic [CAP_EXP-1:0] slots_q;
    logic [SW-1:0]      tick_q;

    // Galois shift, free running so the draw depends on when the collision lands.
    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) begin
            lfsr_d = lfsr_d ^ LFSR_TAPS;
        end
    end

    // Window mask: the low exp_in bits are open.
    always_comb begin
        for (int i = 0; i < CAP_EXP; i++) begin
            mask[i] = (i < int'(exp_in));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q  <= SEED;
            slots_q <= '0;
            tick_q  <= '0;
        end else begin
            lfsr_q <= lfsr_d;
            if (load) begin
                slots_q <= lfsr_q[CAP_EXP-1:0] & mask;
                tick_q  <= SLOT_LAST;
            end else if (slots_q != '0) begin
                if (tick_q == '0) begin
                    slots_q <= slots_q - CAP_EXP'(1);
                    tick_q  <= SLOT_LAST;
                end else begin
                    tick_q <= tick_q - SW'(1);
                end
            end
        end
    end

    assign done = (slots_q == '0);

    assert_draw_capped_R13: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (slots_q <= $past(mask)));

    assert_lfsr_alive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/hdx_retry_seq.sv
module hdx_retry_seq
    import hdx_retry_pkg::*;
#(
    parameter int BUF_DEPTH                = 64,
    parameter int RETRY_LIMIT              = 15,
    parameter int SLOT_CYCLES              = 512,
    parameter int BACKOFF_CAP              = 10,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       in_ready,
    input  logic       col_in,
    input  logic       halt_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_sof,
    output logic       tx_eof,
    output logic       halt_done,
    output logic       err_late,
    output logic       err_retry
);

    localparam int CW = $clog2(BUF_DEPTH + 1);
    localparam int AW = $clog2(BUF_DEPTH);
    localparam int RW = $clog2(RETRY_LIMIT + 1);
    localparam int EW = $clog2(BACKOFF_CAP + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(BUF_DEPTH);
    localparam logic [RW-1:0] LIMIT_C = RW'(RETRY_LIMIT);

    hdx_state_e    state_q, state_d;
    logic [CW-1:0] taken_q, taken_d;   // bytes of the frame pulled from the source (saturating)
    logic [CW-1:0] sent_q,  sent_d;    // bytes sent in the current attempt (saturating)
    logic [RW-1:0] retry_q, retry_d;
    logic          held_q,  held_d;    // a collided frame waits behind the halt

    logic          replaying;
    logic          late_hit;
    logic          limit_hit;
    logic          col_send;
    logic          col_retry;
    logic          buf_wr;
    logic [7:0]    buf_rd;
    logic          bo_load;
    logic [EW-1:0] bo_exp;
    logic          bo_done;

    assign replaying = (sent_q < taken_q);
    assign late_hit  = (sent_q >= DEPTH_C);
    assign limit_hit = (retry_q == LIMIT_C);
    assign col_send  = (state_q == ST_SEND) && col_in;
    assign col_retry = col_send && !late_hit && !limit_hit;
    assign bo_load   = col_retry && !halt_req;
    assign buf_wr    = (state_q == ST_SEND) && !col_in && !replaying && in_valid
                       && (taken_q != DEPTH_C);

    always_comb begin
        if (int'(retry_q) + 1 > BACKOFF_CAP) begin
            bo_exp = EW'(BACKOFF_CAP);
        end else begin
            bo_exp = EW'(int'(retry_q) + 1);
        end
    end

    hdx_replay_mem #(
        .DEPTH (BUF_DEPTH),
        .DW    (8)
    ) i_replay_mem (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_addr (taken_q[AW-1:0]),
        .wr_data (in_data),
        .rd_addr (sent_q[AW-1:0]),
        .rd_data (buf_rd)
    );

    hdx_backoff_timer #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .CAP_EXP     (BACKOFF_CAP),
        .SEED        (LFSR_SEED)
    ) i_backoff_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bo_load),
        .exp_in (bo_exp),
        .done   (bo_done)
    );

    // Next state and attempt bookkeeping.
    always_comb begin
        state_d = state_q;
        taken_d = taken_q;
        sent_d  = sent_q;
        retry_d = retry_q;
        held_d  = held_q;
        unique case (state_q)
            ST_IDLE: begin
                if (halt_req) begin
                    state_d = ST_STOPPED;
                    held_d  = 1'b0;
                end else if (in_valid && in_sof) begin
                    state_d = ST_SEND;
                    taken_d = '0;
                    sent_d  = '0;
                    retry_d = '0;
                end
            end
            ST_SEND: begin
                if (col_in) begin
                    if (late_hit || limit_hit) begin
                        state_d = ST_DRAIN;
                    end else begin
                        retry_d = retry_q + RW'(1);
                        sent_d  = '0;
                        if (halt_req) begin
                            state_d = ST_STOPPED;
                            held_d  = 1'b1;
                        end else begin
                            state_d = ST_BACKOFF;
                        end
                    end
                end else if (replaying) begin
                    sent_d = sent_q + CW'(1);
                end else if (in_valid) begin
                    if (sent_q != DEPTH_C) begin
                        sent_d = sent_q + CW'(1);
                    end
                    if (taken_q != DEPTH_C) begin
                        taken_d = taken_q + CW'(1);
                    end
                    if (in_eof) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BACKOFF: begin
                if (bo_done) begin
                    state_d = ST_SEND;
                end
            end
            ST_DRAIN: begin
                if (in_valid && in_eof) begin
                    state_d = ST_IDLE;
                end
            end
            ST_STOPPED: begin
                if (!halt_req) begin
                    state_d = held_q ? ST_SEND : ST_IDLE;
                    held_d  = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        tx_valid  = 1'b0;
        tx_sof    = 1'b0;
        tx_eof    = 1'b0;
        in_ready  = 1'b0;
        halt_done = 1'b0;
        err_late  = 1'b0;
        err_retry = 1'b0;
        tx_data   = replaying ? buf_rd : in_data;
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = !halt_req && !in_sof;
                halt_done = halt_req;
            end
            ST_SEND: begin
                if (col_in) begin
                    err_late  = late_hit;
                    err_retry = !late_hit && limit_hit;
                    halt_done = col_retry && halt_req;
                end else begin
                    tx_valid = replaying || in_valid;
                    tx_sof   = tx_valid && (sent_q == '0);
                    tx_eof   = !replaying && in_valid && in_eof;
                    in_ready = !replaying;
                end
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
            end
            ST_BACKOFF, ST_STOPPED: begin
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            taken_q <= '0;
            sent_q  <= '0;
            retry_q <= '0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            taken_q <= taken_d;
            sent_q  <= sent_d;
            retry_q <= retry_d;
            held_q  <= held_d;
        end
    end

    assert_col_blocks_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && col_in) |-> (!tx_valid && !in_ready));

    assert_replay_no_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && (sent_q < taken_q)) |-> !in_ready);

    assert_store_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q <= DEPTH_C);

    assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= LIMIT_C);

    assert_drain_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !tx_valid);

    assert_late_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_late |-> (col_in && !err_retry));

    assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |-> (!tx_valid && !in_ready));

    assert_halt_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_done |=> !halt_done);

    assert_halt_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halt_done |-> halt_req);

endmodule

// File: tb/test_hdx_retry_seq.sv
module test_hdx_retry_seq;

    localparam int DEPTH = 8;
    localparam int LIMIT = 3;
    localparam int SLOT  = 3;
    localparam int CAP   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_ready;
    logic       col_in = 1'b0;
    logic       halt_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_sof;
    logic       tx_eof;
    logic       halt_done;
    logic       err_late;
    logic       err_retry;

    always #10 clk = ~clk;   // 20 ns period

    hdx_retry_seq #(
        .BUF_DEPTH   (DEPTH),
        .RETRY_LIMIT (LIMIT),
        .SLOT_CYCLES (SLOT),
        .BACKOFF_CAP (CAP)
    ) i_hdx_retry_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_ready  (in_ready),
        .col_in    (col_in),
        .halt_req  (halt_req),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_sof    (tx_sof),
        .tx_eof    (tx_eof),
        .halt_done (halt_done),
        .err_late  (err_late),
        .err_retry (err_retry)
    );

    int checks = 0;
    int fails  = 0;

    int flen, base, idx, apos, att, cyc;
    int last_col, rel_cyc, hold_left, stop_at;
    int stop_cnt, stop_cyc, tx_cnt;
    int col_pos [8];
    bit src_on, fdone, aborted, stop_path, waiting;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int k);
        return 8'(base + k * 37 + 5);
    endfunction

    task automatic set_cols(input int a, input int b, input int c, input int d, input int e);
        for (int i = 0; i < 8; i++) col_pos[i] = -1;
        col_pos[0] = a; col_pos[1] = b; col_pos[2] = c; col_pos[3] = d; col_pos[4] = e;
    endtask

    task automatic tick();
        @(negedge clk);
        if (stop_at >= 0 && att == 0 && apos == stop_at) halt_req = 1'b1;
        if (waiting) begin
            if (hold_left == 0) begin
                halt_req = 1'b0;
                waiting  = 1'b0;
                rel_cyc  = cyc;
            end else begin
                hold_left--;
            end
        end
        in_valid = src_on && (idx < flen);
        in_data  = fb(idx);
        in_sof   = (idx == 0);
        in_eof   = (idx == flen - 1);
        col_in   = 1'b0;
        #1;
        if (tx_valid && !aborted && att < 8 && col_pos[att] == apos) begin
            col_in = 1'b1;
            #1;
        end
        if (col_in) begin
            automatic bit late = (apos >= DEPTH);
            automatic bit lim  = !late && (att == LIMIT);
            chk(err_late == late, "R8", int'(err_late), int'(late));
            chk(err_retry == lim, "R7", int'(err_retry), int'(lim));
            chk(!tx_valid && !in_ready, "R6", int'(tx_valid) + int'(in_ready), 0);
            if (late || lim) begin
                aborted = 1'b1;
            end else begin
                att++;
                last_col = cyc;
                if (halt_req) begin
                    chk(halt_done == 1'b1, "R12", int'(halt_done), 1);
                    stop_path = 1'b1;
                    waiting   = 1'b1;
                    hold_left = 10;
                end else begin
                    stop_path = 1'b0;
                end
            end
            apos = 0;
        end else begin
            chk(!err_late && !err_retry, "R8", int'(err_late) + int'(err_retry), 0);
            if (tx_valid) begin
                tx_cnt++;
                if (aborted) begin
                    chk(1'b0, "R7", 1, 0);
                end else if (waiting) begin
                    chk(1'b0, "R12", 1, 0);
                end else if (!src_on || fdone) begin
                    chk(1'b0, "R3", 1, 0);
                end else begin
                    chk(tx_data == fb(apos), (att == 0) ? "R2" : "R4", int'(tx_data), int'(fb(apos)));
                    chk(tx_sof == (apos == 0), "R2", int'(tx_sof), int'(apos == 0));
                    chk(tx_eof == (apos == flen - 1), "R2", int'(tx_eof), int'(apos == flen - 1));
                    if (apos < idx) chk(in_ready == 1'b0, "R4", int'(in_ready), 0);
                    else            chk(in_ready == 1'b1, "R2", int'(in_ready), 1);
                    if (apos == 0 && att > 0) begin
                        if (stop_path) begin
                            chk(cyc == rel_cyc + 1, "R12", cyc, rel_cyc + 1);
                        end else begin
                            automatic int g = cyc - last_col;
                            automatic int n = (att > CAP) ? CAP : att;
                            chk(g >= 2 && (g - 2) % SLOT == 0, "R5", g, 2);
                            chk((g - 2) / SLOT <= (1 << n) - 1, "R13", (g - 2) / SLOT, (1 << n) - 1);
                        end
                    end
                    if (tx_eof) fdone = 1'b1;
                    apos++;
                end
            end
        end
        if (halt_done) begin
            stop_cnt++;
            stop_cyc = cyc;
        end
        if (in_valid && in_ready) idx++;
        cyc++;
    endtask

    task automatic start_frame(input int len, input int b);
        flen = len; base = b; idx = 0; apos = 0; att = 0;
        fdone = 1'b0; aborted = 1'b0; stop_path = 1'b0; waiting = 1'b0;
        src_on = 1'b1;
    endtask

    task automatic run_frame(input int len, input int b, input string req);
        int guard;
        start_frame(len, b);
        guard = 0;
        while (!(fdone || (aborted && idx == flen)) && guard < 5000) begin
            tick();
            guard++;
        end
        chk(guard < 5000, req, guard, 5000);
        src_on  = 1'b0;
        stop_at = -1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sc0, tc0, e_cyc;
        stop_at = -1; stop_cnt = 0; tx_cnt = 0; cyc = 0; flen = 0; idx = 0;
        src_on = 1'b0; waiting = 1'b0; aborted = 1'b0; fdone = 1'b0;
        set_cols(-1, -1, -1, -1, -1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        @(negedge clk); #1;
        chk(!tx_valid && !halt_done && !err_late && !err_retry, "R1",
            int'(tx_valid) + int'(halt_done) + int'(err_late) + int'(err_retry), 0);
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

        // R3: stray bytes without a start mark are dropped
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (k == 3); in_data = 8'(k + 9);
            #1;
            chk(in_ready == 1'b1 && tx_valid == 1'b0, "R3", int'(in_ready), 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;

        // R2: plain frames of several lengths
        for (int len = 1; len <= 10; len += 3) begin
            set_cols(-1, -1, -1, -1, -1);
            run_frame(len, len * 11, "R2");
            chk(fdone && att == 0, "R2", int'(fdone), 1);
        end

        // R4, R5, R13: three collisions at varied positions, then success
        set_cols(3, 0, 5, -1, -1);
        run_frame(12, 3, "R4");
        chk(fdone && !aborted, "R4", int'(fdone), 1);

        // R6: collision on the end-marked byte
        set_cols(3, -1, -1, -1, -1);
        run_frame(4, 50, "R6");
        chk(fdone && att == 1, "R6", att, 1);

        // R7: budget spent on the fourth collision
        set_cols(1, 1, 1, 1, -1);
        run_frame(6, 70, "R7");
        chk(aborted && idx == 6, "R7", idx, 6);

        // R9: two collisions, then a frame needing the full budget
        set_cols(1, 0, -1, -1, -1);
        run_frame(5, 90, "R9");
        chk(fdone && !aborted, "R9", int'(aborted), 0);
        set_cols(2, 2, 2, -1, -1);
        run_frame(6, 110, "R9");
        chk(fdone && !aborted && att == 3, "R9", att, 3);

        // R8: collision at DEPTH-1 is retried, at DEPTH is late
        set_cols(DEPTH - 1, DEPTH, -1, -1, -1);
        run_frame(14, 130, "R8");
        chk(aborted && att == 1, "R8", att, 1);

        // R10: halt while idle
        sc0 = stop_cnt; tc0 = tx_cnt;
        halt_req = 1'b1;
        set_cols(-1, -1, -1, -1, -1);
        start_frame(3, 150);
        e_cyc = cyc;
        for (int k = 0; k < 6; k++) tick();
        chk(stop_cnt == sc0 + 1 && stop_cyc == e_cyc, "R10", stop_cyc, e_cyc);
        chk(idx == 0 && tx_cnt == tc0, "R10", idx, 0);
        halt_req = 1'b0;
        run_frame(3, 150, "R10");
        chk(fdone, "R10", int'(fdone), 1);

        // R11: halt during a frame waits for its end
        sc0 = stop_cnt;
        stop_at = 2;
        set_cols(-1, -1, -1, -1, -1);
        run_frame(6, 170, "R11");
        e_cyc = cyc;
        tick();
        chk(stop_cnt == sc0 + 1 && stop_cyc == e_cyc, "R11", stop_cyc, e_cyc);
        for (int k = 0; k < 4; k++) tick();
        chk(stop_cnt == sc0 + 1, "R11", stop_cnt, sc0 + 1);
        halt_req = 1'b0;
        tick();

        // R12: halt pending when a collision hits
        sc0 = stop_cnt;
        stop_at = 1;
        set_cols(2, -1, -1, -1, -1);
        run_frame(7, 190, "R12");
        chk(fdone && stop_cnt == sc0 + 1, "R12", stop_cnt, sc0 + 1);

        // frame after all of the above runs clean
        set_cols(-1, -1, -1, -1, -1);
        run_frame(9, 210, "R2");
        chk(fdone, "R2", int'(fdone), 1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule